// File: doc/BRIEF.md
# Register Frame Save/Restore Sequencer

This block carries out the compressed push and pop operations of a 32-bit processor. It takes a 4-bit list code and a 2-bit stack-immediate code and works out which registers to move: the return-address register, optionally followed by a run of callee-saved registers. It also works out how large the stack frame must be. It then moves one 32-bit word per register through a single-beat memory port, walking the frame from its highest slot down to its lowest.

A push reads each register through a register-file read port and stores it. A pop loads each word and writes it back through a register-file write port. The two return variants end the pop with a jump to the restored return address. The zero variant also clears a0 in the same cycle.

The stack pointer arrives as an input and is sampled with the start strobe. The new stack pointer is written exactly once, in the cycle that finishes the operation. An illegal list code produces a one-cycle done with the illegal flag set and has no other effect.

Top module: `regstk_seq`

## Requirements
- R1: List codes 0 to 3 are illegal. When the reduced-register option is set, codes 7 to 15 are also illegal. An illegal start gives done and illegal together in the cycle after start, with no memory request, no register write, no stack-pointer write and no jump.
- R2: A legal code N in 4 to 14 moves N-3 registers: ra plus s0..s(N-5). Code 15 moves 13 registers: ra plus s0..s11. Exactly one memory beat is made per register.
- R3: The slot mapping is fixed. Slot 0 is x1 (ra). s0 is x8 and s1 is x9. s2 to s11 are x18 to x27.
- R4: The frame size is the register bytes (4 per register) rounded up to a multiple of 16, plus 16 times the stack-immediate code. This gives 16, 32, 48 and 64 bytes for codes 4-7, 8-11, 12-14 and 15.
- R5: A push (op code 0) stores the highest-numbered s register at sp-4 and each next register 4 bytes lower. ra is stored last, at the lowest address. The store data is the value read from the register file for that register.
- R6: A pop (op codes 1, 2 and 3) loads in the same register order, starting at sp+frame-4 and moving down by 4. Each loaded word is written to its register in the cycle its beat completes.
- R7: The stack pointer is written once per legal operation, in the done cycle and never earlier. A push writes sp-frame and a pop writes sp+frame.
- R8: Op code 2 jumps, in the done cycle, to the restored ra with bit 0 cleared. Op code 3 does the same and also writes 0 to x10 in that cycle. Op codes 0 and 1 never jump.
- R9: The memory request and its address stay stable until ready is seen. No new request is issued until the previous beat's done has arrived.
- R10: After reset, done, request and all write strobes are low. Done lasts one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | 0 push, 1 pop, 2 pop and return, 3 pop and return with a0 cleared |
| rlist | input | 4 | Register-list code |
| spimm | input | 2 | Extra frame space in 16-byte units |
| sp_in | input | 32 | Current stack pointer |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a store |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_done | input | 1 | Accepted beat completed |
| mem_rdata | input | 32 | Load data, valid with mem_done |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wdata | output | 32 | New stack pointer |
| jump | output | 1 | Jump strobe |
| jump_target | output | 32 | Jump target address |
| done | output | 1 | Operation finished |
| illegal | output | 1 | Operation rejected |

## Verification
The assertions assume the memory side keeps to the single-beat protocol. Ready is only raised against a live request. Done follows ready in a later cycle and is never raised without an accepted beat. The stack pointer is assumed word aligned.

The bench's memory responder accepts each request after a random gap and completes it one to three cycles later, so it never overlaps beats. It always supplies 16-byte aligned stack pointers. Start is raised only while the block is idle.

// File: rtl/regstk_pkg.sv
`timescale 1ns/1ps
package regstk_pkg;

   typedef enum logic [1:0] {
      STK_PUSH    = 2'd0,
      STK_POP     = 2'd1,
      STK_POPRET  = 2'd2,
      STK_POPRETZ = 2'd3
   } stk_op_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_REQ,
      SQ_WAIT,
      SQ_FIN,
      SQ_BAD
   } sq_state_e;

   localparam logic [4:0] RA_XREG = 5'd1;
   localparam logic [4:0] A0_XREG = 5'd10;

   // Slot 0 is ra; slot k>0 holds s(k-1), split across two x-register ranges.
   function automatic logic [4:0] slot_xreg(input logic [3:0] slot);
      if (slot == 4'd0)
         return RA_XREG;
      else if (slot < 4'd3)
         return 5'd7 + {1'b0, slot};
      else
         return 5'd15 + {1'b0, slot};
   endfunction

endpackage

// File: rtl/regstk_frame.sv
`timescale 1ns/1ps
module regstk_frame #(
   parameter int unsigned WORD_B   = 4,
   parameter int unsigned LIST_W   = 4,
   parameter int unsigned IMM_W    = 2,
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned FRAME_W  = 8,
   parameter bit          EMBEDDED = 1'b0
) (
   input  logic [LIST_W-1:0]  list_code,
   input  logic [IMM_W-1:0]   imm_code,
   output logic               legal,
   output logic [CNT_W-1:0]   reg_count,
   output logic [FRAME_W-1:0] frame_bytes
);
   localparam int unsigned ALIGN     = 16;
   localparam int unsigned FULL_CNT  = 13;
   localparam int unsigned FIRST_OK  = 4;
   localparam int unsigned EMB_LAST  = 6;
   localparam int unsigned CNT_SKEW  = 3;

   logic               above_floor;
   logic [FRAME_W-1:0] need_bytes;
   logic [FRAME_W-1:0] base_bytes;

   assign above_floor = list_code >= LIST_W'(FIRST_OK);

   generate
      if (EMBEDDED) begin : g_reduced
         assign legal = above_floor && (list_code <= LIST_W'(EMB_LAST));
      end else begin : g_full
         assign legal = above_floor;
      end
   endgenerate

   always_comb begin
      if (list_code == '1)
         reg_count = CNT_W'(FULL_CNT);
      else
         reg_count = CNT_W'(list_code) - CNT_W'(CNT_SKEW);
   end

   assign need_bytes  = FRAME_W'(reg_count) * FRAME_W'(WORD_B);
   assign base_bytes  = (need_bytes + FRAME_W'(ALIGN - 1)) & ~FRAME_W'(ALIGN - 1);
   assign frame_bytes = base_bytes + (FRAME_W'(imm_code) << 4);

   always_comb begin
      if (legal) begin
         assert_frame_fits_R4: assert (frame_bytes[3:0] == 4'd0 && frame_bytes >= need_bytes);
      end
   end

endmodule

// File: rtl/regstk_walk.sv
`timescale 1ns/1ps
module regstk_walk #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned WORD_B  = 4,
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic               is_push,
   input  logic [XLEN-1:0]    sp,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   count,
   output logic [CNT_W-1:0]   slot,
   output logic [XLEN-1:0]    addr,
   output logic               last
);
   localparam logic [XLEN-1:0] STRIDE = XLEN'(WORD_B);

   logic [XLEN-1:0] top_addr;

   assign top_addr = is_push ? (sp - STRIDE) : (sp + XLEN'(frame) - STRIDE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot <= '0;
         addr <= '0;
      end else if (load) begin
         slot <= count - CNT_W'(1);
         addr <= top_addr;
      end else if (step) begin
         slot <= slot - CNT_W'(1);
         addr <= addr - STRIDE;
      end
   end

   assign last = (slot == '0);

   assert_no_step_past_ra_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !last);

endmodule

// File: rtl/regstk_fsm.sv
`timescale 1ns/1ps
module regstk_fsm
   import regstk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      legal,
   input  logic      mem_ready,
   input  logic      mem_done,
   input  logic      last,
   output sq_state_e state,
   output logic      load,
   output logic      step
);
   sq_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         SQ_IDLE: if (start) nxt = legal ? SQ_REQ : SQ_BAD;
         SQ_REQ:  if (mem_ready) nxt = SQ_WAIT;
         SQ_WAIT: if (mem_done) nxt = last ? SQ_FIN : SQ_REQ;
         SQ_FIN:  nxt = SQ_IDLE;
         SQ_BAD:  nxt = SQ_IDLE;
         default: nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= SQ_IDLE;
      else        state <= nxt;
   end

   assign load = (state == SQ_IDLE) && start && legal;
   assign step = (state == SQ_WAIT) && mem_done && !last;

   assert_reject_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && start && !legal) |=> (state == SQ_BAD));

endmodule

// File: rtl/regstk_seq.sv
`timescale 1ns/1ps
module regstk_seq
   import regstk_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned REG_AW   = 5,
   parameter int unsigned LIST_W   = 4,
   parameter int unsigned IMM_W    = 2,
   parameter bit          EMBEDDED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [LIST_W-1:0] rlist,
   input  logic [IMM_W-1:0]  spimm,
   input  logic [XLEN-1:0]   sp_in,
   output logic [REG_AW-1:0] rf_raddr,
   input  logic [XLEN-1:0]   rf_rdata,
   output logic              rf_we,
   output logic [REG_AW-1:0] rf_waddr,
   output logic [XLEN-1:0]   rf_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [XLEN-1:0]   mem_addr,
   output logic [XLEN-1:0]   mem_wdata,
   input  logic              mem_ready,
   input  logic              mem_done,
   input  logic [XLEN-1:0]   mem_rdata,
   output logic              sp_we,
   output logic [XLEN-1:0]   sp_wdata,
   output logic              jump,
   output logic [XLEN-1:0]   jump_target,
   output logic              done,
   output logic              illegal
);
   localparam int unsigned WORD_B  = XLEN / 8;
   localparam int unsigned CNT_W   = LIST_W;
   localparam int unsigned FRAME_W = 8;

   generate
      if (XLEN != 32 || LIST_W != 4 || IMM_W != 2 || REG_AW != 5) begin : g_bad_cfg
         initial $fatal(1, "regstk_seq: only the 32-bit, 4-bit list, 2-bit immediate layout is supported");
      end
   endgenerate

   logic               legal;
   logic [CNT_W-1:0]   count;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   slot;
   logic [XLEN-1:0]    walk_addr;
   logic               last;
   logic               load;
   logic               step;
   sq_state_e          state;

   stk_op_e            op_q;
   logic [XLEN-1:0]    sp_q;
   logic [FRAME_W-1:0] frame_q;
   logic [XLEN-1:0]    ra_q;
   logic               is_push;
   logic               beat_end;
   logic [REG_AW-1:0]  slot_reg;

   regstk_frame #(
      .WORD_B(WORD_B), .LIST_W(LIST_W), .IMM_W(IMM_W),
      .CNT_W(CNT_W), .FRAME_W(FRAME_W), .EMBEDDED(EMBEDDED)
   ) u_frame (
      .list_code(rlist), .imm_code(spimm),
      .legal(legal), .reg_count(count), .frame_bytes(frame)
   );

   regstk_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .legal(legal),
      .mem_ready(mem_ready), .mem_done(mem_done), .last(last),
      .state(state), .load(load), .step(step)
   );

   regstk_walk #(
      .XLEN(XLEN), .WORD_B(WORD_B), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .is_push(stk_op_e'(op) == STK_PUSH), .sp(sp_in), .frame(frame),
      .count(count), .slot(slot), .addr(walk_addr), .last(last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= STK_PUSH;
         sp_q    <= '0;
         frame_q <= '0;
         ra_q    <= '0;
      end else begin
         if (load) begin
            op_q    <= stk_op_e'(op);
            sp_q    <= sp_in;
            frame_q <= frame;
         end
         if (beat_end && last && !is_push)
            ra_q <= mem_rdata;
      end
   end

   assign is_push  = (op_q == STK_PUSH);
   assign beat_end = (state == SQ_WAIT) && mem_done;
   assign slot_reg = REG_AW'(slot_xreg(slot));

   assign rf_raddr  = slot_reg;
   assign mem_req   = (state == SQ_REQ);
   assign mem_we    = is_push;
   assign mem_addr  = walk_addr;
   assign mem_wdata = rf_rdata;

   always_comb begin
      rf_we    = 1'b0;
      rf_waddr = slot_reg;
      rf_wdata = mem_rdata;
      if (beat_end && !is_push) begin
         rf_we = 1'b1;
      end else if (state == SQ_FIN && op_q == STK_POPRETZ) begin
         rf_we    = 1'b1;
         rf_waddr = REG_AW'(A0_XREG);
         rf_wdata = '0;
      end
   end

   assign done        = (state == SQ_FIN) || (state == SQ_BAD);
   assign illegal     = (state == SQ_BAD);
   assign sp_we       = (state == SQ_FIN);
   assign sp_wdata    = is_push ? (sp_q - XLEN'(frame_q)) : (sp_q + XLEN'(frame_q));
   assign jump        = (state == SQ_FIN) && (op_q == STK_POPRET || op_q == STK_POPRETZ);
   assign jump_target = {ra_q[XLEN-1:1], 1'b0};

   assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   assert_no_req_while_waiting_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready) |=> !mem_req);

   assert_addr_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   assert_sp_only_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |-> (done && !mem_req && !illegal));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_jump_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
      jump |-> (done && !jump_target[0]));

   assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (done && !sp_we && !rf_we && !mem_req && !jump));

   assert_write_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (rf_waddr == 5'd1 || rf_waddr == 5'd8 || rf_waddr == 5'd9 ||
                 (rf_waddr >= 5'd18 && rf_waddr <= 5'd27) ||
                 (rf_waddr == 5'd10 && done)));

endmodule

// File: tb/regstk_seq_bench.sv
`timescale 1ns/1ps
module regstk_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        start = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [3:0]  rlist = 4'd0;
   logic [1:0]  spimm = 2'd0;
   logic [31:0] sp_in = 32'd0;
   logic [4:0]  rf_raddr;
   logic [31:0] rf_rdata;
   logic        rf_we;
   logic [4:0]  rf_waddr;
   logic [31:0] rf_wdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ready = 1'b0;
   logic        mem_done = 1'b0;
   logic [31:0] mem_rdata = 32'd0;
   logic        sp_we, jump, done, illegal;
   logic [31:0] sp_wdata, jump_target;

   logic        start_e = 1'b0;
   logic [3:0]  rlist_e = 4'd0;
   logic [4:0]  e_raddr, e_waddr;
   logic        e_rf_we, e_req, e_we, e_sp_we, e_jump, done_e, illegal_e;
   logic [31:0] e_wdata, e_addr, e_mwdata, e_spw, e_tgt;

   regstk_seq u_regstk_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .rlist(rlist),
      .spimm(spimm), .sp_in(sp_in), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_done(mem_done),
      .mem_rdata(mem_rdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
      .jump(jump), .jump_target(jump_target), .done(done), .illegal(illegal)
   );

   regstk_seq #(.EMBEDDED(1'b1)) u_regstk_seq_emb (
      .clk(clk), .rst_n(rst_n), .start(start_e), .op(2'd1), .rlist(rlist_e),
      .spimm(2'd0), .sp_in(32'h0000_0800), .rf_raddr(e_raddr), .rf_rdata(32'd0),
      .rf_we(e_rf_we), .rf_waddr(e_waddr), .rf_wdata(e_wdata),
      .mem_req(e_req), .mem_we(e_we), .mem_addr(e_addr),
      .mem_wdata(e_mwdata), .mem_ready(1'b0), .mem_done(1'b0),
      .mem_rdata(32'd0), .sp_we(e_sp_we), .sp_wdata(e_spw),
      .jump(e_jump), .jump_target(e_tgt), .done(done_e), .illegal(illegal_e)
   );

   // Behavioural register file and memory
   logic [31:0] brf [32];
   logic [31:0] bmem [1024];
   assign rf_rdata = brf[rf_raddr];
   always @(posedge clk) if (rf_we) brf[rf_waddr] <= rf_wdata;

   int checks = 0;
   int errors = 0;

   logic [31:0] q_addr [$];
   logic [31:0] q_data [$];
   bit          q_we   [$];
   logic [4:0]  r_addr [$];
   logic [31:0] r_data [$];
   logic [31:0] x_sp, x_tgt;
   bit          x_jump, x_ill;
   bit          done_seen = 1'b0;

   task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", msg, act, exp);
      end
   endtask

   function automatic logic [4:0] xreg_of(input int slot);
      int s;
      if (slot == 0) return 5'd1;
      s = slot - 1;
      if (s < 2) return 5'(8 + s);
      return 5'(16 + s);
   endfunction

   // Memory responder: random accept gap, done 1..3 cycles after accept
   int          gap = 0;
   int          wait_cnt = 0;
   logic [31:0] cap_addr, cap_wdata;
   bit          cap_we;
   always @(negedge clk) begin
      mem_ready = 1'b0;
      mem_done  = 1'b0;
      if (!rst_n) begin
         wait_cnt = 0;
         gap = 0;
      end else if (wait_cnt > 0) begin
         wait_cnt--;
         if (wait_cnt == 0) begin
            mem_done = 1'b1;
            if (cap_we) bmem[cap_addr[11:2]] = cap_wdata;
            mem_rdata = bmem[cap_addr[11:2]];
         end
      end else if (mem_req) begin
         if (gap > 0) gap--;
         else begin
            mem_ready = 1'b1;
            cap_addr  = mem_addr;
            cap_we    = mem_we;
            cap_wdata = mem_wdata;
            wait_cnt  = 1 + int'($urandom % 3);
            gap       = int'($urandom % 3);
         end
      end
   end

   // Per-cycle comparison against the expected event queues
   bit          prev_req = 1'b0, prev_rdy = 1'b0, prev_done = 1'b0;
   logic [31:0] prev_addr = 32'd0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (prev_req && !prev_rdy)
            check(mem_req && mem_addr == prev_addr, "R9 request not held", mem_addr, prev_addr);
         if (mem_req && !mem_ready && wait_cnt > 0)
            check(1'b0, "R9 request while beat outstanding", 32'd1, 32'd0);
         if (mem_req && x_ill)
            check(1'b0, "R1 memory request on illegal code", 32'd1, 32'd0);
         if (mem_req && mem_ready) begin
            if (q_addr.size() == 0) check(1'b0, "R2 extra memory beat", mem_addr, 32'd0);
            else begin
               check(mem_addr == q_addr[0], q_we[0] ? "R5 push address" : "R6 pop address", mem_addr, q_addr[0]);
               check(mem_we == q_we[0], "R5 R6 beat direction", 32'(mem_we), 32'(q_we[0]));
               if (q_we[0]) check(mem_wdata == q_data[0], "R3 R5 push data", mem_wdata, q_data[0]);
               void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_we.pop_front());
            end
         end
         if (rf_we) begin
            if (r_addr.size() == 0) check(1'b0, "R6 unexpected register write", 32'(rf_waddr), 32'd0);
            else begin
               check(rf_waddr == r_addr[0], "R3 R6 R8 write index", 32'(rf_waddr), 32'(r_addr[0]));
               check(rf_wdata == r_data[0], "R6 R8 write data", rf_wdata, r_data[0]);
               void'(r_addr.pop_front()); void'(r_data.pop_front());
            end
         end
         if (sp_we && !done) check(1'b0, "R7 early sp write", 32'd1, 32'd0);
         if (jump && !done) check(1'b0, "R8 jump outside done", 32'd1, 32'd0);
         if (done) begin
            check(!prev_done, "R10 done wider than one cycle", 32'(prev_done), 32'd0);
            check(illegal == x_ill, "R1 illegal flag", 32'(illegal), 32'(x_ill));
            if (x_ill) begin
               check(!sp_we && !jump && !rf_we, "R1 side effect on illegal", {29'd0, sp_we, jump, rf_we}, 32'd0);
            end else begin
               check(sp_we, "R7 sp write in done cycle", 32'(sp_we), 32'd1);
               check(sp_wdata == x_sp, "R4 R7 new stack pointer", sp_wdata, x_sp);
               check(jump == x_jump, "R8 jump strobe", 32'(jump), 32'(x_jump));
               if (x_jump) check(jump_target == x_tgt, "R8 jump target", jump_target, x_tgt);
               check(q_addr.size() == 0 && r_addr.size() == 0, "R2 beats left at done",
                     32'(q_addr.size() + r_addr.size()), 32'd0);
            end
            done_seen = 1'b1;
         end
         prev_req  = mem_req;
         prev_rdy  = mem_ready;
         prev_addr = mem_addr;
         prev_done = done;
      end
   end

   task automatic run_op(input int op, input int list, input int imm, input logic [31:0] sp);
      int n, frame, t;
      logic [31:0] a;
      logic [31:0] ra;
      ra = 32'd0;
      if (list >= 4) begin
         n = (list == 15) ? 13 : list - 3;
         frame = ((n * 4 + 15) / 16) * 16 + imm * 16;
         for (int k = n - 1; k >= 0; k--) begin
            a = (op == 0) ? sp - 32'(4 * (n - k)) : sp + 32'(frame) - 32'(4 * (n - k));
            q_addr.push_back(a);
            q_we.push_back(op == 0);
            if (op == 0) q_data.push_back(brf[xreg_of(k)]);
            else begin
               q_data.push_back(bmem[a[11:2]]);
               r_addr.push_back(xreg_of(k));
               r_data.push_back(bmem[a[11:2]]);
               if (k == 0) ra = bmem[a[11:2]];
            end
         end
         if (op == 3) begin
            r_addr.push_back(5'd10);
            r_data.push_back(32'd0);
         end
         x_sp   = (op == 0) ? sp - 32'(frame) : sp + 32'(frame);
         x_jump = (op >= 2);
         x_tgt  = ra & ~32'd1;
         x_ill  = 1'b0;
      end else begin
         x_ill  = 1'b1;
         x_jump = 1'b0;
      end
      @(negedge clk);
      start = 1'b1; op_i = 2'(op); rlist = 4'(list); spimm = 2'(imm); sp_in = sp;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done_seen && t < 3000) begin
         @(negedge clk);
         t++;
      end
      if (!done_seen) check(1'b0, "R10 done never raised", 32'd0, 32'd1);
      done_seen = 1'b0;
      x_ill = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_emb(input int list, input bit exp_ill);
      @(negedge clk);
      start_e = 1'b1; rlist_e = 4'(list);
      @(negedge clk);
      start_e = 1'b0;
      #1;
      check((done_e && illegal_e) == exp_ill, "R1 reduced-register legality", 32'(done_e && illegal_e), 32'(exp_ill));
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) brf[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0003;
      for (int i = 0; i < 1024; i++) bmem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0001_0207);
      repeat (3) @(negedge clk);
      #1;
      check(!done && !mem_req && !sp_we && !rf_we && !jump, "R10 reset state",
            {27'd0, done, mem_req, sp_we, rf_we, jump}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      run_op(0, 4, 0, 32'h0000_0800);   // R2 ra only
      run_op(0, 15, 3, 32'h0000_0800);  // R2 R4 full set, largest frame
      run_op(1, 15, 3, 32'h0000_0790);  // R6 restore
      run_op(0, 8, 1, 32'h0000_0700);
      run_op(1, 8, 1, 32'h0000_06D0);
      run_op(0, 14, 0, 32'h0000_0600);
      bmem[32'h52C >> 2] = 32'h0000_1235;
      run_op(2, 12, 2, 32'h0000_0500);  // R8 odd ra
      bmem[32'h400 >> 2] = 32'h0000_2001;
      run_op(3, 7, 0, 32'h0000_0400);   // R8 a0 cleared
      run_op(1, 5, 2, 32'h0000_0300);
      run_op(0, 0, 0, 32'h0000_0800);   // R1
      run_op(3, 3, 1, 32'h0000_0800);   // R1
      run_op(2, 2, 0, 32'h0000_0800);   // R1
      run_emb(7, 1'b1);
      run_emb(15, 1'b1);
      run_emb(3, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule